// File: doc/BRIEF.md
# Tightly-Coupled Memory Address Router

This block decides where each instruction fetch and each data access goes: to a tightly-coupled memory (TCM) next to the core, or out to the system bus. A small control register file holds two enable bits. One enable bit is for the instruction TCM, which sits at address 0. The other is for the data TCM, which sits in a window at a parameterised base address. Both TCMs have the same power-of-two size. Each access is accepted with a valid strobe. One cycle later the block returns a registered route select and the forwarded address. An access routed to a TCM carries its offset inside that TCM. An access routed to the bus carries its full address.

After reset the instruction TCM is disabled, so fetches from low addresses travel over the system bus. They move to the instruction TCM only once software sets the enable bit. The data TCM starts enabled. Flash at its physical base (0x0C00_0000) is never inside a TCM window, so it stays reachable over the bus in every enable state. A change to an enable bit applies to accesses accepted after the write. An access accepted in the same cycle as the write still uses the old setting.

Top module: `tcm_router`

## Requirements
- R1: The instruction-TCM control register is at cfg_addr offset 0xF90. Its enable is bit 0 and it resets to 0. A read returns the enable in bit 0 with all other bits zero, on cfg_rdata one cycle after cfg_rd_en. cfg_rdata holds its value in cycles with no read.
- R2: The data-TCM control register is at offset 0xF94, with its enable in bit 0. The enable resets to 1. Writing 0 disables the data TCM and writing 1 enables it again.
- R3: A write to any other offset changes neither enable, and a read from any other offset returns zero. Write-data bits above bit 0 are ignored.
- R4: With the instruction enable set, a fetch whose address is below TCM_BYTES gives ifetch_to_tcm=1 one cycle after acceptance.
- R5: With the instruction enable clear, every fetch gives ifetch_to_tcm=0. This includes every fetch made after reset and before the first enable write.
- R6: A fetch at or above TCM_BYTES always goes to the bus. This includes the flash base 0x0C00_0000.
- R7: A data access inside [DTCM_BASE, DTCM_BASE+TCM_BYTES) gives dacc_to_tcm=1 only while the data enable is set. Any other data access gives dacc_to_tcm=0.
- R8: Each out_valid equals the matching input valid of the previous cycle. The forwarded address is the address modulo TCM_BYTES when the access is routed to a TCM, and the unchanged address when it is routed to the bus. When out_valid is 0, the route and the address read 0.
- R9: An enable write takes effect for accesses accepted in later cycles. An access accepted in the same cycle as the write is routed by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_rd_en | input | 1 | Control register read strobe |
| cfg_addr | input | 12 | Control register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ifetch_valid | input | 1 | Instruction fetch request valid |
| ifetch_addr | input | 32 | Instruction fetch address |
| dacc_valid | input | 1 | Data access request valid |
| dacc_addr | input | 32 | Data access address |
| ifetch_out_valid | output | 1 | Routed fetch valid |
| ifetch_to_tcm | output | 1 | 1 = instruction TCM, 0 = system bus |
| ifetch_out_addr | output | 32 | Forwarded fetch address |
| dacc_out_valid | output | 1 | Routed data access valid |
| dacc_to_tcm | output | 1 | 1 = data TCM, 0 = system bus |
| dacc_out_addr | output | 32 | Forwarded data address |

## Verification
The assertions assume that the address inputs are known whenever their valid strobe is high. They also assume that TCM_BYTES is smaller than the distance from either TCM base to the next window or to flash. The stimulus meets both conditions. It draws addresses only from the two TCM windows, their edges, the flash region and a bounded random range, and it drives every address input with a defined value on every cycle. Enable writes are interleaved at random with accesses, so that same-cycle write-and-access cases come up often.

// File: rtl/tcm_router_pkg.sv
// Shared types for the TCM router.
// Assumes: nothing beyond IEEE 1800-2017.
package tcm_router_pkg;
    typedef enum logic {
        RT_BUS = 1'b0,
        RT_TCM = 1'b1
    } route_t;
endpackage

// File: rtl/tcm_ctrl_regs.sv
// Two-bit control register file: instruction-TCM enable and data-TCM enable.
// Assumes: the offsets are distinct. Read data is registered and held between reads.
module tcm_ctrl_regs #(
    parameter int               CFG_AW   = 12,
    parameter int               DW       = 32,
    parameter logic [CFG_AW-1:0] ITCM_OFS = 12'hF90,
    parameter logic [CFG_AW-1:0] DTCM_OFS = 12'hF94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              itcm_en,
    output logic              dtcm_en
);
    logic hit_i;
    logic hit_d;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DW-1:1];

    // Decode which register the offset names.
    always_comb begin
        hit_i = (addr == ITCM_OFS);
        hit_d = (addr == DTCM_OFS);
    end

    // Enable bits: instruction TCM off after reset, data TCM on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            itcm_en <= 1'b0;
            dtcm_en <= 1'b1;
        end else if (wr_en) begin
            if (hit_i) itcm_en <= wdata[0];
            if (hit_d) dtcm_en <= wdata[0];
        end
    end

    // Registered read port; returns the pre-write value on a simultaneous write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= {{(DW-1){1'b0}}, (hit_i & itcm_en) | (hit_d & dtcm_en)};
        end
    end
endmodule

// File: rtl/tcm_window_hit.sv
// Tests whether an address falls inside an aligned power-of-two window.
// Assumes: SIZE is a power of two below 2**ADDR_W and BASE is aligned to SIZE.
module tcm_window_hit #(
    parameter int               ADDR_W = 32,
    parameter int               SIZE   = 65536,
    parameter logic [ADDR_W-1:0] BASE  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int OFS_W = $clog2(SIZE);

    // Only the bits above the window offset take part in the compare.
    always_comb begin
        hit = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    end
endmodule

// File: rtl/tcm_route_lane.sv
// One routing lane. It latches the route and the forwarded address of an accepted access.
// Assumes: the enable is sampled in the acceptance cycle. The route then never changes for that access.
module tcm_route_lane
    import tcm_router_pkg::*;
#(
    parameter int               ADDR_W = 32,
    parameter int               SIZE   = 65536,
    parameter logic [ADDR_W-1:0] BASE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              enable,
    output logic              out_valid,
    output route_t            out_route,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int OFS_W = $clog2(SIZE);

    logic              in_window;
    route_t            next_route;
    logic [ADDR_W-1:0] next_addr;

    tcm_window_hit #(
        .ADDR_W (ADDR_W),
        .SIZE   (SIZE),
        .BASE   (BASE)
    ) u_win (
        .addr (in_addr),
        .hit  (in_window)
    );

    // Choose the route and the form of the forwarded address.
    always_comb begin
        next_route = (in_window && enable) ? RT_TCM : RT_BUS;
        next_addr  = (next_route == RT_TCM)
                   ? {{(ADDR_W-OFS_W){1'b0}}, in_addr[OFS_W-1:0]}
                   : in_addr;
    end

    // Output stage; it reads zero whenever no access was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            out_route <= RT_BUS;
            out_addr  <= '0;
        end else begin
            out_valid <= 1'b1;
            out_route <= next_route;
            out_addr  <= next_addr;
        end
    end
endmodule

// File: rtl/tcm_router.sv
// Top: a control register file plus an instruction lane and a data lane.
// Assumes: both TCMs have size TCM_BYTES. The instruction TCM sits at 0 and the data TCM at DTCM_BASE.
module tcm_router
    import tcm_router_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DW        = 32,
    parameter int          CFG_AW    = 12,
    parameter int          TCM_BYTES = 65536,
    parameter logic [31:0] DTCM_BASE = 32'h2000_0000,
    parameter logic [11:0] ITCM_OFS  = 12'hF90,
    parameter logic [11:0] DTCM_OFS  = 12'hF94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              ifetch_valid,
    input  logic [ADDR_W-1:0] ifetch_addr,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    output logic              ifetch_out_valid,
    output logic              ifetch_to_tcm,
    output logic [ADDR_W-1:0] ifetch_out_addr,
    output logic              dacc_out_valid,
    output logic              dacc_to_tcm,
    output logic [ADDR_W-1:0] dacc_out_addr
);
    logic   itcm_en;
    logic   dtcm_en;
    route_t if_route;
    route_t da_route;

    tcm_ctrl_regs #(
        .CFG_AW   (CFG_AW),
        .DW       (DW),
        .ITCM_OFS (ITCM_OFS),
        .DTCM_OFS (DTCM_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .rd_en   (cfg_rd_en),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .itcm_en (itcm_en),
        .dtcm_en (dtcm_en)
    );

    tcm_route_lane #(
        .ADDR_W (ADDR_W),
        .SIZE   (TCM_BYTES),
        .BASE   ('0)
    ) u_ilane (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ifetch_valid),
        .in_addr   (ifetch_addr),
        .enable    (itcm_en),
        .out_valid (ifetch_out_valid),
        .out_route (if_route),
        .out_addr  (ifetch_out_addr)
    );

    tcm_route_lane #(
        .ADDR_W (ADDR_W),
        .SIZE   (TCM_BYTES),
        .BASE   (DTCM_BASE[ADDR_W-1:0])
    ) u_dlane (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dacc_valid),
        .in_addr   (dacc_addr),
        .enable    (dtcm_en),
        .out_valid (dacc_out_valid),
        .out_route (da_route),
        .out_addr  (dacc_out_addr)
    );

    // Turn the lane routes into plain select bits.
    always_comb begin
        ifetch_to_tcm = (if_route == RT_TCM);
        dacc_to_tcm   = (da_route == RT_TCM);
    end
endmodule

// File: rtl/tcm_router_checker.sv
// Port-level properties of tcm_router, bound to every instance.
// Assumes: the address inputs are known while their valid strobe is high.
module tcm_router_checker #(
    parameter int          ADDR_W    = 32,
    parameter int          DW        = 32,
    parameter int          TCM_BYTES = 65536,
    parameter logic [31:0] DTCM_BASE = 32'h2000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DW-1:0]     cfg_rdata,
    input logic              ifetch_valid,
    input logic [ADDR_W-1:0] ifetch_addr,
    input logic              dacc_valid,
    input logic [ADDR_W-1:0] dacc_addr,
    input logic              ifetch_out_valid,
    input logic              ifetch_to_tcm,
    input logic [ADDR_W-1:0] ifetch_out_addr,
    input logic              dacc_out_valid,
    input logic              dacc_to_tcm,
    input logic [ADDR_W-1:0] dacc_out_addr
);
    localparam int OFS_W = $clog2(TCM_BYTES);
    localparam logic [ADDR_W-1:0] DB = DTCM_BASE[ADDR_W-1:0];

    assert_rdata_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DW-1:1] == '0);

    assert_tcm_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch_to_tcm || dacc_to_tcm) |-> ((!ifetch_to_tcm || ifetch_out_valid) && (!dacc_to_tcm || dacc_out_valid)));

    assert_ifetch_outside_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch_valid && ifetch_addr[ADDR_W-1:OFS_W] != '0) |=> !ifetch_to_tcm);

    assert_dacc_outside_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc_valid && dacc_addr[ADDR_W-1:OFS_W] != DB[ADDR_W-1:OFS_W]) |=> !dacc_to_tcm);

    assert_ifetch_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ifetch_out_valid == $past(ifetch_valid)));

    assert_dacc_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dacc_out_valid == $past(dacc_valid)));

    assert_tcm_addr_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch_to_tcm || dacc_to_tcm) |->
            ((!ifetch_to_tcm || ifetch_out_addr[ADDR_W-1:OFS_W] == '0) &&
             (!dacc_to_tcm || dacc_out_addr[ADDR_W-1:OFS_W] == '0)));

    assert_bus_addr_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch_valid && ifetch_addr[ADDR_W-1:OFS_W] != '0) |=> (ifetch_out_addr == $past(ifetch_addr)));
endmodule

bind tcm_router tcm_router_checker #(
    .ADDR_W    (ADDR_W),
    .DW        (DW),
    .TCM_BYTES (TCM_BYTES),
    .DTCM_BASE (DTCM_BASE)
) u_tcm_router_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_rdata        (cfg_rdata),
    .ifetch_valid     (ifetch_valid),
    .ifetch_addr      (ifetch_addr),
    .dacc_valid       (dacc_valid),
    .dacc_addr        (dacc_addr),
    .ifetch_out_valid (ifetch_out_valid),
    .ifetch_to_tcm    (ifetch_to_tcm),
    .ifetch_out_addr  (ifetch_out_addr),
    .dacc_out_valid   (dacc_out_valid),
    .dacc_to_tcm      (dacc_to_tcm),
    .dacc_out_addr    (dacc_out_addr)
);

// File: tb/tcm_router_bench.sv
module tcm_router_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          TCM_BYTES  = 65536;
    localparam logic [31:0] DTCM_BASE  = 32'h2000_0000;
    localparam logic [31:0] FLASH_BASE = 32'h0C00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        ifetch_valid = 1'b0, dacc_valid = 1'b0;
    logic [31:0] ifetch_addr = '0, dacc_addr = '0;
    logic        ifetch_out_valid, ifetch_to_tcm, dacc_out_valid, dacc_to_tcm;
    logic [31:0] ifetch_out_addr, dacc_out_addr;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_iten, m_dten;
    bit          have_exp = 1'b0, exp_rd = 1'b0;
    logic [31:0] exp_rdata;
    logic [33:0] exp_if, exp_da;   // {valid, to_tcm, addr}
    string       exp_tag;

    tcm_router u_tcm_router (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
        .ifetch_out_valid(ifetch_out_valid), .ifetch_to_tcm(ifetch_to_tcm),
        .ifetch_out_addr(ifetch_out_addr), .dacc_out_valid(dacc_out_valid),
        .dacc_to_tcm(dacc_to_tcm), .dacc_out_addr(dacc_out_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [33:0] exp_lane(bit v, logic [31:0] a, logic [31:0] base, bit en);
        bit hit;
        hit = ((a - base) < TCM_BYTES) && (a >= base);
        if (!v) return '0;
        if (hit && en) return {1'b1, 1'b1, a & (TCM_BYTES - 1)};
        return {1'b1, 1'b0, a};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic compare();
        logic [33:0] a_if, a_da;
        a_if = {ifetch_out_valid, ifetch_to_tcm, ifetch_out_addr};
        a_da = {dacc_out_valid, dacc_to_tcm, dacc_out_addr};
        if (have_exp) begin
            chk(a_if == exp_if, {exp_tag, " ifetch"}, 64'(a_if), 64'(exp_if));
            chk(a_da == exp_da, {exp_tag, " dacc"}, 64'(a_da), 64'(exp_da));
        end
        if (exp_rd) chk(cfg_rdata == exp_rdata, {exp_tag, " rdata"}, 64'(cfg_rdata), 64'(exp_rdata));
    endtask

    // one cycle: check previous results, drive new inputs, predict
    task automatic step(bit wr, bit rd, logic [11:0] ca, logic [31:0] wd,
                        bit iv, logic [31:0] ia, bit dv, logic [31:0] da, string tag);
        @(negedge clk);
        compare();
        cfg_wr_en = wr; cfg_rd_en = rd; cfg_addr = ca; cfg_wdata = wd;
        ifetch_valid = iv; ifetch_addr = ia; dacc_valid = dv; dacc_addr = da;
        have_exp = 1'b1;
        exp_if = exp_lane(iv, ia, 32'h0, m_iten);
        exp_da = exp_lane(dv, da, DTCM_BASE, m_dten);
        exp_rd = rd;
        if (rd) exp_rdata = (ca == 12'hF90) ? 32'(m_iten) : (ca == 12'hF94) ? 32'(m_dten) : 32'h0;
        exp_tag = tag;
        if (wr && ca == 12'hF90) m_iten = wd[0];
        if (wr && ca == 12'hF94) m_dten = wd[0];
    endtask

    function automatic logic [31:0] pick_addr(logic [31:0] base);
        case ($urandom_range(0, 5))
            0: return base + ($urandom & (TCM_BYTES - 1));
            1: return base + TCM_BYTES - 1;
            2: return base + TCM_BYTES;
            3: return FLASH_BASE + ($urandom & 32'hFFFF);
            4: return (base == 0) ? DTCM_BASE + 4 : 32'h10;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        m_iten = 1'b0; m_dten = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R8: outputs zero
        chk({ifetch_out_valid, ifetch_to_tcm, dacc_out_valid, dacc_to_tcm, cfg_rdata} == '0,
            "R8 reset outputs", 64'({ifetch_out_valid, ifetch_to_tcm, dacc_out_valid, dacc_to_tcm}), 64'h0);
        rst_n = 1'b1;
        step(0, 1, 12'hF90, 0, 0, 0, 0, 0, "R1 itcm reset value");
        step(0, 1, 12'hF94, 0, 0, 0, 0, 0, "R2 dtcm reset value");
        step(0, 0, 0, 0, 1, 32'h0, 0, 0, "R5 fetch at 0 after reset");
        step(0, 0, 0, 0, 1, 32'h100, 0, 0, "R5 low fetch disabled");
        step(1, 0, 12'hF90, 1, 1, 32'h10, 0, 0, "R9 same-cycle write old route");
        step(0, 0, 0, 0, 1, 32'h10, 0, 0, "R9 next fetch uses new route R4");
        step(0, 1, 12'hF90, 0, 1, TCM_BYTES - 1, 0, 0, "R4 last itcm byte R1");
        step(0, 0, 0, 0, 1, TCM_BYTES, 0, 0, "R6 first address past itcm");
        step(0, 0, 0, 0, 1, FLASH_BASE, 1, DTCM_BASE + 4, "R6 flash base R7");
        step(1, 0, 12'hF98, 0, 0, 0, 0, 0, "R3 write unmapped offset");
        step(0, 1, 12'hF98, 0, 1, 32'h20, 0, 0, "R3 unmapped read zero");
        step(1, 0, 12'hF94, 32'hFFFF_FFFE, 1, DTCM_BASE, 1, DTCM_BASE + TCM_BYTES - 1, "R3 upper bits ignored R2");
        step(0, 1, 12'hF94, 0, 0, 0, 1, DTCM_BASE + 8, "R7 dtcm disabled to bus R2");
        step(1, 0, 12'hF94, 1, 0, 0, 1, DTCM_BASE + TCM_BYTES, "R7 past dtcm window");
        step(0, 0, 0, 0, 0, 0, 1, DTCM_BASE - 1, "R7 below dtcm window R8");
        step(1, 0, 12'hF90, 0, 1, 32'h4, 1, DTCM_BASE + 4, "R9 disable write keeps old route");
        step(0, 0, 0, 0, 1, 32'h4, 0, 0, "R5 fetch after disable");
        for (int i = 0; i < 3000; i++) begin
            bit wr = ($urandom_range(0, 7) == 0);
            bit rd = ($urandom_range(0, 3) == 0);
            logic [11:0] ca = ($urandom_range(0, 3) == 0) ? 12'(32'hF80 + 4 * $urandom_range(0, 7))
                            : ($urandom_range(0, 1) ? 12'hF90 : 12'hF94);
            step(wr, rd, ca, $urandom, $urandom_range(0, 1), pick_addr(32'h0),
                 $urandom_range(0, 1), pick_addr(DTCM_BASE), "R4 R5 R6 R7 R8 R9 random");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle flush");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule